// File: doc/BRIEF.md
# Indirect Auto-Increment Memory Access Port

This block lets a host that owns only a narrow command/data bus reach a large local display memory through a pointer instead of a wide address bus. The host first loads a 17-bit byte pointer through three byte-wide pointer registers. These writes only fill a staging copy. A command write to the start register copies the staged value into the live pointer and arms the port. After that, each data cycle on the host bus becomes one access to the memory at the live pointer. The pointer then advances by the size of the access.

Data accesses are one byte or one 16-bit word. A byte access uses the memory lane chosen by address bit 0. A word access is stored little-endian and may only start at an even address. A word access at an odd address is refused, leaves the pointer where it was and latches an error flag. The port answers data cycles only while the mode input selects the indirect mode. Outside that mode, data cycles have no effect.

The memory side is a plain synchronous port: enable, write enable, byte address, two byte enables, write data, and read data that returns one cycle after the request.

Top module: `ind_mem_port`

## Requirements
- R1: After reset the staged pointer reads as zero, the status register (index C3h) reads zero with error in bit 0 and armed in bit 1, and `memEn` stays low.
- R2: Command writes to index C0h, C1h and C2h load staged pointer bits 7:0, bits 15:8 and bit 16 from `hostWdata[7:0]`, `hostWdata[7:0]` and `hostWdata[0]` respectively. Command reads of those indices return the staged value, with the unused upper bits of C2h read as zero.
- R3: Writes to the pointer registers do not move the live pointer. A command write to index C4h copies the staged pointer into the live pointer, sets armed and clears the error flag.
- R4: A data cycle issued before the first start command after reset causes no memory access.
- R5: A byte data access drives `memBe` 2'b01 when the live pointer is even and 2'b10 when it is odd. The byte travels on `hostWdata[7:0]` or `hostRdata[7:0]` (upper read bits zero), and the pointer then advances by 1.
- R6: A word data access drives `memBe` 2'b11, stores `hostWdata[7:0]` at the even address and `hostWdata[15:8]` at the next address, reads back in the same order, and advances the pointer by 2.
- R7: A word access at an odd live pointer performs no memory access, leaves the pointer unchanged and sets a sticky error flag (status bit 0), which only the next start command clears.
- R8: When `modeCfg` is not 3'b111, data cycles perform no memory access and leave the live pointer unchanged.
- R9: The live pointer wraps from 0x1FFFF (and from 0x1FFFE for a word) to 0.
- R10: Register and data read results appear on `hostRdata` in the cycle after the request and hold until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeCfg | input | 3 | Interface mode select; 3'b111 enables the port |
| hostSel | input | 1 | Host cycle strobe, one cycle per request |
| hostCmd | input | 1 | 1 = register (command) cycle, 0 = data cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostWord | input | 1 | Data cycle size: 1 = word, 0 = byte |
| hostAddr | input | 8 | Register index for command cycles |
| hostWdata | input | 16 | Write data from host |
| hostRdata | output | 16 | Read data to host, registered |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 17 | Memory byte address (word select is bits 16:1) |
| memBe | output | 2 | Byte-lane enables, bit 0 = even byte |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid the cycle after a read |

## Verification
The assertions assume that each host request lasts exactly one cycle with `hostSel` high and that the memory returns read data one cycle after an enabled read. Under that assumption, two back-to-back memory strobes must always differ in address by the size of the first access. The bench keeps within this by issuing every request from a single task that raises `hostSel` for one cycle only. The bench itself plays a memory with exactly one cycle of read latency. Changes to the mode input happen only between requests, never inside one.

// File: rtl/ind_mem_port_pkg.sv
package ind_mem_port_pkg;
  localparam logic [7:0] REG_PTR_LO  = 8'hC0;
  localparam logic [7:0] REG_PTR_MID = 8'hC1;
  localparam logic [7:0] REG_PTR_HI  = 8'hC2;
  localparam logic [7:0] REG_STATUS  = 8'hC3;
  localparam logic [7:0] REG_START   = 8'hC4;
  localparam logic [2:0] MODE_INDIRECT = 3'b111;

  typedef struct packed {
    logic ldLo;
    logic ldMid;
    logic ldHi;
    logic arm;
    logic memGo;
    logic memWrite;
    logic wordOp;
    logic fault;
    logic capRead;
  } strobe_t;
endpackage

// File: rtl/ind_mem_port_ctrl.sv
module ind_mem_port_ctrl
  import ind_mem_port_pkg::*;
(
  input  logic [2:0] modeCfg,
  input  logic       hostSel,
  input  logic       hostCmd,
  input  logic       hostWr,
  input  logic       hostWord,
  input  logic [7:0] hostAddr,
  input  logic       armed,
  input  logic       activeOdd,
  output strobe_t    stb
);
  logic cmdWrite;
  logic dataReq;

  always_comb begin
    cmdWrite = hostSel && hostCmd && hostWr;
    dataReq  = hostSel && !hostCmd && armed && (modeCfg == MODE_INDIRECT);

    stb          = '0;
    stb.ldLo     = cmdWrite && (hostAddr == REG_PTR_LO);
    stb.ldMid    = cmdWrite && (hostAddr == REG_PTR_MID);
    stb.ldHi     = cmdWrite && (hostAddr == REG_PTR_HI);
    stb.arm      = cmdWrite && (hostAddr == REG_START);
    stb.capRead  = hostSel && hostCmd && !hostWr;
    stb.fault    = dataReq && hostWord && activeOdd;
    stb.memGo    = dataReq && !stb.fault;
    stb.memWrite = hostWr;
    stb.wordOp   = hostWord;
  end
endmodule

// File: rtl/ind_mem_port_dp.sv
module ind_mem_port_dp
  import ind_mem_port_pkg::*;
#(
  parameter int PTR_W  = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              armed,
  output logic              activeOdd,
  output logic              memEn,
  output logic              memWe,
  output logic [PTR_W-1:0]  memAddr,
  output logic [1:0]        memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int HALF_W = DATA_W / 2;
  localparam int HI_W   = PTR_W - 16;

  logic [PTR_W-1:0]  shadowPtr;
  logic [PTR_W-1:0]  activePtr;
  logic              errFlag;
  logic [DATA_W-1:0] regQ;
  logic [DATA_W-1:0] regMux;
  logic              fromMem;
  logic              laneHiQ;
  logic              wordQ;
  logic [PTR_W-1:0]  stepVal;

  assign activeOdd = activePtr[0];
  assign stepVal   = stb.wordOp ? PTR_W'(2) : PTR_W'(1);

  always_comb begin
    regMux = '0;
    case (hostAddr)
      REG_PTR_LO:  regMux[7:0]      = shadowPtr[7:0];
      REG_PTR_MID: regMux[7:0]      = shadowPtr[15:8];
      REG_PTR_HI:  regMux[HI_W-1:0] = shadowPtr[PTR_W-1:16];
      REG_STATUS:  regMux[1:0]      = {armed, errFlag};
      default:     regMux           = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowPtr <= '0;
      activePtr <= '0;
      armed     <= 1'b0;
      errFlag   <= 1'b0;
      regQ      <= '0;
      fromMem   <= 1'b0;
      laneHiQ   <= 1'b0;
      wordQ     <= 1'b0;
    end else begin
      if (stb.ldLo)  shadowPtr[7:0]       <= hostWdata[7:0];
      if (stb.ldMid) shadowPtr[15:8]      <= hostWdata[7:0];
      if (stb.ldHi)  shadowPtr[PTR_W-1:16] <= hostWdata[HI_W-1:0];
      if (stb.arm) begin
        activePtr <= shadowPtr;
        armed     <= 1'b1;
        errFlag   <= 1'b0;
      end
      if (stb.memGo) activePtr <= activePtr + stepVal;
      if (stb.fault) errFlag <= 1'b1;
      if (stb.capRead) begin
        regQ    <= regMux;
        fromMem <= 1'b0;
      end
      if (stb.memGo && !stb.memWrite) begin
        fromMem <= 1'b1;
        laneHiQ <= activePtr[0];
        wordQ   <= stb.wordOp;
      end
    end
  end

  always_comb begin
    if (!fromMem)   hostRdata = regQ;
    else if (wordQ) hostRdata = memRdata;
    else if (laneHiQ)
      hostRdata = {{HALF_W{1'b0}}, memRdata[DATA_W-1:HALF_W]};
    else
      hostRdata = {{HALF_W{1'b0}}, memRdata[HALF_W-1:0]};
  end

  always_comb begin
    memEn    = stb.memGo;
    memWe    = stb.memGo && stb.memWrite;
    memAddr  = activePtr;
    memBe    = 2'b00;
    if (stb.memGo)
      memBe = stb.wordOp ? 2'b11 : (activePtr[0] ? 2'b10 : 2'b01);
    memWdata = stb.wordOp ? hostWdata : {2{hostWdata[HALF_W-1:0]}};
  end
endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
  import ind_mem_port_pkg::*;
#(
  parameter int PTR_W  = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeCfg,
  input  logic              hostSel,
  input  logic              hostCmd,
  input  logic              hostWr,
  input  logic              hostWord,
  input  logic [7:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [PTR_W-1:0]  memAddr,
  output logic [1:0]        memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  strobe_t stb;
  logic    armed;
  logic    activeOdd;

  ind_mem_port_ctrl ctrl_i (
    .modeCfg  (modeCfg),
    .hostSel  (hostSel),
    .hostCmd  (hostCmd),
    .hostWr   (hostWr),
    .hostWord (hostWord),
    .hostAddr (hostAddr),
    .armed    (armed),
    .activeOdd(activeOdd),
    .stb      (stb)
  );

  ind_mem_port_dp #(.PTR_W(PTR_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .armed    (armed),
    .activeOdd(activeOdd),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memBe    (memBe),
    .memWdata (memWdata),
    .memRdata (memRdata)
  );
endmodule

// File: rtl/ind_mem_port_chk.sv
module ind_mem_port_chk #(
  parameter int PTR_W  = 17,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        modeCfg,
  input logic              hostSel,
  input logic              hostCmd,
  input logic              memEn,
  input logic              memWe,
  input logic [PTR_W-1:0]  memAddr,
  input logic [1:0]        memBe
);
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (modeCfg != 3'b111) |-> !memEn); // R8

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memBe == 2'b11) |-> !memAddr[0]); // R7

  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memBe != 2'b11) |-> (memBe == (memAddr[0] ? 2'b10 : 2'b01))); // R5

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && $past(memEn)) |->
      (memAddr == PTR_W'($past(memAddr) + (($past(memBe) == 2'b11) ? 2 : 1)))); // R6

  AST_NO_ACCESS_UNREQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    (!hostSel || hostCmd) |-> (!memEn && !memWe)); // R4
endmodule

bind ind_mem_port ind_mem_port_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .modeCfg(modeCfg),
  .hostSel(hostSel),
  .hostCmd(hostCmd),
  .memEn  (memEn),
  .memWe  (memWe),
  .memAddr(memAddr),
  .memBe  (memBe)
);

// File: tb/ind_mem_port_tb_top.sv
`timescale 1ns/1ps
module ind_mem_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeCfg = 3'b111;
  logic        hostSel = 1'b0, hostCmd = 1'b0, hostWr = 1'b0, hostWord = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        memEn, memWe;
  logic [16:0] memAddr;
  logic [1:0]  memBe;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [16:0] refShadow = '0;
  logic [16:0] refAct = '0;
  bit          refArmed = 0;
  bit          refErr = 0;
  logic [7:0]  refMem [int];
  // bench-side memory behind the port
  logic [15:0] benchMem [int];

  always #2 clk = ~clk;

  ind_mem_port dut_i (
    .clk(clk), .rstN(rstN), .modeCfg(modeCfg), .hostSel(hostSel),
    .hostCmd(hostCmd), .hostWr(hostWr), .hostWord(hostWord),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memEn) begin
      logic [15:0] w;
      int k;
      k = int'(memAddr[16:1]);
      w = benchMem.exists(k) ? benchMem[k] : 16'h0;
      if (memWe) begin
        if (memBe[0]) w[7:0]  = memWdata[7:0];
        if (memBe[1]) w[15:8] = memWdata[15:8];
        benchMem[k] = w;
      end else begin
        memRdata <= w;
      end
    end
  end

  function automatic logic [7:0] rb(input logic [16:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hostSel = 1'b0;
      #1;
      chk(memEn == 1'b0, "R4", "idle memEn", 32'(memEn), 0);
    end
  endtask

  task automatic op(input logic cmd, input logic wr, input logic word,
                    input logic [7:0] a, input logic [15:0] d, input string tag);
    logic expEn;
    logic [1:0] expBe;
    logic [15:0] expRd;
    bit chkRd;
    bit fault;
    expEn = 0; expBe = 2'b00; expRd = '0; chkRd = 0; fault = 0;
    @(negedge clk);
    hostSel = 1'b1; hostCmd = cmd; hostWr = wr; hostWord = word;
    hostAddr = a; hostWdata = d;
    if (cmd) begin
      if (!wr) begin
        chkRd = 1;
        case (a)
          8'hC0: expRd = {8'h00, refShadow[7:0]};
          8'hC1: expRd = {8'h00, refShadow[15:8]};
          8'hC2: expRd = {15'h0, refShadow[16]};
          8'hC3: expRd = {14'h0, refArmed, refErr};
          default: expRd = 16'h0;
        endcase
      end
    end else if (modeCfg == 3'b111 && refArmed) begin
      if (word && refAct[0]) fault = 1;
      else begin
        expEn = 1;
        expBe = word ? 2'b11 : (refAct[0] ? 2'b10 : 2'b01);
        if (!wr) begin
          chkRd = 1;
          expRd = word ? {rb(refAct + 17'd1), rb(refAct)} : {8'h00, rb(refAct)};
        end
      end
    end
    #1;
    chk(memEn == expEn, tag, "memEn", 32'(memEn), 32'(expEn));
    if (expEn) begin
      chk(memAddr == refAct, tag, "memAddr", 32'(memAddr), 32'(refAct));
      chk(memBe == expBe, tag, "memBe", 32'(memBe), 32'(expBe));
      chk(memWe == wr, tag, "memWe", 32'(memWe), 32'(wr));
      if (wr && expBe[0])
        chk(memWdata[7:0] == d[7:0], tag, "low lane", 32'(memWdata[7:0]), 32'(d[7:0]));
      if (wr && expBe[1]) begin
        logic [7:0] hiExp;
        hiExp = word ? d[15:8] : d[7:0];
        chk(memWdata[15:8] == hiExp, tag, "high lane", 32'(memWdata[15:8]), 32'(hiExp));
      end
    end
    @(posedge clk);
    #1;
    hostSel = 1'b0;
    if (chkRd)
      chk(hostRdata == expRd, tag, "hostRdata", 32'(hostRdata), 32'(expRd));
    // model update
    if (cmd && wr) begin
      case (a)
        8'hC0: refShadow[7:0]  = d[7:0];
        8'hC1: refShadow[15:8] = d[7:0];
        8'hC2: refShadow[16]   = d[0];
        8'hC4: begin refAct = refShadow; refArmed = 1; refErr = 0; end
        default: ;
      endcase
    end
    if (fault) refErr = 1;
    if (expEn) begin
      if (wr) begin
        refMem[int'(refAct)] = d[7:0];
        if (word) refMem[int'(refAct + 17'd1)] = d[15:8];
      end
      refAct = refAct + (word ? 17'd2 : 17'd1);
    end
  endtask

  task automatic setPtr(input logic [16:0] p, input string tag);
    op(1, 1, 0, 8'hC0, {8'h00, p[7:0]}, tag);
    op(1, 1, 0, 8'hC1, {8'h00, p[15:8]}, tag);
    op(1, 1, 0, 8'hC2, {15'h0, p[16]}, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    chk(memEn == 1'b0, "R1", "reset memEn", 32'(memEn), 0);
    rstN = 1'b1;
    idle(2);
    // R1: reset values read back
    op(1, 0, 0, 8'hC0, 0, "R1");
    op(1, 0, 0, 8'hC1, 0, "R1");
    op(1, 0, 0, 8'hC2, 0, "R1");
    op(1, 0, 0, 8'hC3, 0, "R1");
    // R4: data before any start is ignored
    op(0, 1, 0, 8'h00, 16'h00AB, "R4");
    op(0, 0, 1, 8'h00, 0, "R4");
    // R2: pointer register layout, C2 upper bits read zero
    op(1, 1, 0, 8'hC0, 16'hFF34, "R2");
    op(1, 1, 0, 8'hC1, 16'hEE12, "R2");
    op(1, 1, 0, 8'hC2, 16'h00FF, "R2");
    op(1, 0, 0, 8'hC0, 0, "R2");
    op(1, 0, 0, 8'hC1, 0, "R2");
    op(1, 0, 0, 8'hC2, 0, "R2");
    // R3: start loads staged pointer; later staging does not move live pointer
    setPtr(17'h00010, "R3");
    op(1, 1, 0, 8'hC4, 0, "R3");
    setPtr(17'h11234, "R3");
    op(0, 1, 0, 8'h00, 16'h0077, "R3");
    op(1, 1, 0, 8'hC4, 0, "R3");
    // R6 / R5: word then bytes on both lanes
    op(0, 1, 1, 8'h00, 16'hBEEF, "R6");
    op(0, 1, 0, 8'h00, 16'h00AA, "R5");
    op(0, 1, 0, 8'h00, 16'h0055, "R5");
    op(1, 1, 0, 8'hC4, 0, "R3");
    op(0, 0, 1, 8'h00, 0, "R6");
    op(0, 0, 0, 8'h00, 0, "R5");
    idle(1);
    op(1, 0, 0, 8'hC3, 0, "R10");
    // R7: odd word refused, pointer unchanged, sticky flag
    op(0, 0, 1, 8'h00, 0, "R7");
    op(0, 1, 1, 8'h00, 16'h1234, "R7");
    op(1, 0, 0, 8'hC3, 0, "R7");
    op(0, 0, 0, 8'h00, 0, "R7");
    op(1, 0, 0, 8'hC3, 0, "R7");
    // R8: other modes ignore data cycles
    modeCfg = 3'b011;
    op(0, 1, 1, 8'h00, 16'hDEAD, "R8");
    op(0, 0, 0, 8'h00, 0, "R8");
    modeCfg = 3'b111;
    op(0, 0, 1, 8'h00, 0, "R8");
    // R9: wrap at the top of the address space
    setPtr(17'h1FFFE, "R9");
    op(1, 1, 0, 8'hC4, 0, "R9");
    op(1, 0, 0, 8'hC3, 0, "R7");
    op(0, 1, 1, 8'h00, 16'hCAFE, "R9");
    op(0, 1, 0, 8'h00, 16'h0011, "R9");
    setPtr(17'h1FFFF, "R9");
    op(1, 1, 0, 8'hC4, 0, "R9");
    op(0, 0, 0, 8'h00, 0, "R9");
    op(0, 0, 0, 8'h00, 0, "R9");
    setPtr(17'h1FFFE, "R9");
    op(1, 1, 0, 8'hC4, 0, "R9");
    op(0, 0, 1, 8'h00, 0, "R9");
    // mixed burst
    lfsr = 16'hACE1;
    setPtr(17'h00100, "R5");
    op(1, 1, 0, 8'hC4, 0, "R3");
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0: op(0, 1, 0, 8'h00, lfsr, "R5");
        3'd1: op(0, 0, 0, 8'h00, 0, "R5");
        3'd2: op(0, 1, 1, 8'h00, lfsr, "R6");
        3'd3: op(0, 0, 1, 8'h00, 0, "R6");
        3'd4: begin
          setPtr({9'h001, lfsr[15:8]}, "R3");
          op(1, 1, 0, 8'hC4, 0, "R3");
        end
        3'd5: op(1, 0, 0, 8'hC3, 0, "R7");
        3'd6: idle(1);
        default: op(0, 0, 0, 8'h00, 0, "R10");
      endcase
    end
    idle(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule